// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block turns 16-bit two's-complement stereo sample pairs into a single serial data line for an external receiver. It runs as a slave. The bit clock, the channel clock (left/right) and the word clock all come in from outside. The block samples them with its own system clock, detects their edges and advances its shifter on the edge chosen as the launch edge.

A two-bit format select picks one of four framings:

- two left-justified variants, one without and one with a one-bit MSB delay;
- a right-justified variant whose MSB sits a fixed 16 bit periods after the channel-clock transition;
- a word-clock-triggered variant.

A polarity input picks which bit-clock edge the data is valid on. A mute input replaces the data with zero (midscale) samples.

Software or an upstream engine offers the next pair through a one-deep holding register with a valid/ready handshake. At each frame start the pending pair becomes the active pair. If no pair is pending, the old pair is sent again and a sticky underrun flag rises. The format and polarity selects take effect only at frame starts, so a frame already in progress is never torn. The reset is synchronous and active-high.

Top module: `serial_audio_tx`

## Requirements
- R1: With `clk_inv`=0, `ser_out` changes only after a falling `bit_clk` edge and is valid at the rising edge. With `clk_inv`=1 these roles swap: it changes after a rising edge and is valid at the falling edge.
- R2: Format 2'b00: in each channel half, the bit periods are counted from 0, and period 0 is the one launched at the channel-clock transition. Periods 0..15 carry sample bits 15 down to 0, and all other periods carry 0.
- R3: Format 2'b01: periods 1..16 carry bits 15 down to 0. Period 0 and all later periods carry 0.
- R4: Format 2'b10: periods 16..31 carry bits 15 down to 0. Periods 0..15 carry 0.
- R5: Format 2'b11: the word clock is sampled at each launch edge. The period after one in which it is seen high is word period 0. Word periods 0..15 carry bits 15 down to 0, and all other periods carry 0. The channel is the `chan_clk` level in word period 0.
- R6: While `mute` is 1 at a launch edge, the bit launched there is 0.
- R7: During reset, `ser_out`=0, `pair_ready`=1 and `underrun`=0. After reset, `ser_out` stays 0 until the first frame start.
- R8: A frame start is a launch edge at which `chan_clk` is seen high after being seen low at the previous launch edge. The left sample is sent while `chan_clk` is high, and the right sample while it is low.
- R9: `pair_ready` is 1 exactly when the holding register is empty. A pair is accepted when `pair_valid` and `pair_ready` are both 1. It becomes the active pair at the next frame start, and the holding register is then empty again.
- R10: At a frame start with nothing pending, the previous active pair (zero after reset) is repeated and `underrun` rises. `underrun` stays high until reset.
- R11: `fmt_sel` and `clk_inv` are captured during reset and at frame starts only. A change at any other time does not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | External serial bit clock |
| chan_clk | input | 1 | External channel clock: high = left, low = right |
| word_clk | input | 1 | External word-start pulse, used by format 2'b11 |
| fmt_sel | input | 2 | Framing format select |
| clk_inv | input | 1 | Bit-clock polarity select |
| mute | input | 1 | Forces zero samples on the serial line |
| pair_valid | input | 1 | Offered sample pair is valid |
| pair_ready | output | 1 | Holding register can accept a pair |
| left_smp | input | 16 | Left sample, two's complement |
| right_smp | input | 16 | Right sample, two's complement |
| ser_out | output | 1 | Serial data output |
| underrun | output | 1 | Sticky flag: a frame start found no new pair |

## Verification
The bench builds the block with 16-bit samples, a right-justify delay of 16, a two-flop synchronizer and 8-bit slot counters. It drives 32 bit clocks per channel half with five system clocks per bit-clock phase. At that rate the right-justified window fills the last 16 periods exactly, so every slot outside the active window of each format is also checked for zero. All four formats run under both polarities. The word-clock format is run once with the word starting mid-half and once with it starting exactly at the channel transition. A mid-frame format change, a muted frame and a skipped load are also exercised, each against a behavioural reference.

// File: rtl/atx_pkg.sv
package atx_pkg;

  typedef enum logic [1:0] {
    FMT_LJ     = 2'b00,
    FMT_LJ_DLY = 2'b01,
    FMT_RJ     = 2'b10,
    FMT_WORD   = 2'b11
  } fmt_e;

endpackage

// File: rtl/atx_edge_sync.sv
// Brings the three external clocks into the system clock domain through
// one shared chain and turns the selected bit-clock edge into a strobe.
module atx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic bit_clk,
  input  logic chan_clk,
  input  logic word_clk,
  input  logic inv,
  output logic adv,
  output logic chan_lvl,
  output logic word_lvl
);

  logic [2:0] raw;
  logic [2:0] tap;
  logic       bclk_d;

  assign raw = {bit_clk, chan_clk, word_clk};

  generate
    if (STAGES <= 1) begin : g_one
      logic [2:0] s_q;
      always_ff @(posedge clk) s_q <= raw;
      assign tap = s_q;
    end else begin : g_chain
      logic [STAGES-1:0][2:0] s_q;
      always_ff @(posedge clk) s_q <= {s_q[STAGES-2:0], raw};
      assign tap = s_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) bclk_d <= tap[2];

  // Launch edge: falling when inv=0, rising when inv=1.
  assign adv      = inv ? (tap[2] & ~bclk_d) : (~tap[2] & bclk_d);
  assign chan_lvl = tap[1];
  assign word_lvl = tap[0];

endmodule

// File: rtl/atx_slot_track.sv
// Counts bit periods since the last channel transition and since the last
// word-clock pulse; both counters saturate.
module atx_slot_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             chan_lvl,
  input  logic             word_lvl,
  output logic             frame_start,
  output logic [CNT_W-1:0] slot_nx,
  output logic [CNT_W-1:0] wslot_nx,
  output logic             wch_nx
);

  localparam logic [CNT_W-1:0] SAT = '1;

  logic             lr_prev_q;
  logic             wc_prev_q;
  logic             wch_q;
  logic [CNT_W-1:0] slot_q;
  logic [CNT_W-1:0] wslot_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == SAT) ? v : v + 1'b1;
  endfunction

  always_comb begin
    slot_nx  = (chan_lvl != lr_prev_q) ? '0 : bump(slot_q);
    wslot_nx = wc_prev_q ? '0 : bump(wslot_q);
    wch_nx   = wc_prev_q ? chan_lvl : wch_q;
  end

  assign frame_start = adv & chan_lvl & ~lr_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_prev_q <= 1'b1;   // a low level must be seen before the first start
      wc_prev_q <= 1'b0;
      wch_q     <= 1'b0;
      slot_q    <= SAT;
      wslot_q   <= SAT;
    end else if (adv) begin
      lr_prev_q <= chan_lvl;
      wc_prev_q <= word_lvl;
      wch_q     <= wch_nx;
      slot_q    <= slot_nx;
      wslot_q   <= wslot_nx;
    end
  end

endmodule

// File: rtl/atx_sample_hold.sv
// One-deep holding register feeding the active pair at frame starts.
module atx_sample_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_valid,
  input  logic [DW-1:0] load_l,
  input  logic [DW-1:0] load_r,
  output logic          load_ready,
  input  logic          take,
  output logic [DW-1:0] act_l_nx,
  output logic [DW-1:0] act_r_nx,
  output logic          underrun
);

  logic          full_q;
  logic [DW-1:0] hold_l_q, hold_r_q;
  logic [DW-1:0] act_l_q, act_r_q;

  assign load_ready = ~full_q;
  assign act_l_nx   = (take && full_q) ? hold_l_q : act_l_q;
  assign act_r_nx   = (take && full_q) ? hold_r_q : act_r_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q   <= 1'b0;
      hold_l_q <= '0;
      hold_r_q <= '0;
      act_l_q  <= '0;
      act_r_q  <= '0;
      underrun <= 1'b0;
    end else begin
      if (take && full_q) begin
        act_l_q <= hold_l_q;
        act_r_q <= hold_r_q;
        full_q  <= 1'b0;
      end else if (take) begin
        underrun <= 1'b1;
      end
      if (load_valid && !full_q) begin
        hold_l_q <= load_l;
        hold_r_q <= load_r;
        full_q   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/atx_bit_pick.sv
// Chooses the bit for the current period from format and slot counters.
module atx_bit_pick
  import atx_pkg::*;
#(
  parameter int DW       = 16,
  parameter int RJ_DELAY = 16,
  parameter int CNT_W    = 8
) (
  input  fmt_e             fmt,
  input  logic [CNT_W-1:0] slot,
  input  logic [CNT_W-1:0] wslot,
  input  logic             chan,
  input  logic             wch,
  input  logic [DW-1:0]    left,
  input  logic [DW-1:0]    right,
  output logic             bit_o
);

  localparam int IW = (DW > 1) ? $clog2(DW) : 1;

  int            s, w, pos;
  logic          hit;
  logic [DW-1:0] word;
  logic [IW-1:0] pos_w;

  always_comb begin
    s    = int'(slot);
    w    = int'(wslot);
    word = chan ? left : right;
    hit  = 1'b0;
    pos  = 0;
    unique case (fmt)
      FMT_LJ: begin
        hit = (s < DW);
        pos = DW - 1 - s;
      end
      FMT_LJ_DLY: begin
        hit = (s >= 1) && (s <= DW);
        pos = DW - s;
      end
      FMT_RJ: begin
        hit = (s >= RJ_DELAY) && (s < RJ_DELAY + DW);
        pos = DW - 1 - (s - RJ_DELAY);
      end
      FMT_WORD: begin
        word = wch ? left : right;
        hit  = (w < DW);
        pos  = DW - 1 - w;
      end
      default: hit = 1'b0;
    endcase
    pos_w = IW'(pos);
    bit_o = hit & word[pos_w];
  end

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import atx_pkg::*;
#(
  parameter int DW          = 16,
  parameter int RJ_DELAY    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_clk,
  input  logic          chan_clk,
  input  logic          word_clk,
  input  logic [1:0]    fmt_sel,
  input  logic          clk_inv,
  input  logic          mute,
  input  logic          pair_valid,
  output logic          pair_ready,
  input  logic [DW-1:0] left_smp,
  input  logic [DW-1:0] right_smp,
  output logic          ser_out,
  output logic          underrun
);

  fmt_e             fmt_q, fmt_nx;
  logic             inv_q;
  logic             armed_q, armed_nx;
  logic             adv, chan_lvl, word_lvl, frame_start;
  logic [CNT_W-1:0] slot_nx, wslot_nx;
  logic             wch_nx;
  logic [DW-1:0]    act_l, act_r;
  logic             pick_bit;

  atx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .bit_clk  (bit_clk),
    .chan_clk (chan_clk),
    .word_clk (word_clk),
    .inv      (inv_q),
    .adv      (adv),
    .chan_lvl (chan_lvl),
    .word_lvl (word_lvl)
  );

  atx_slot_track #(.CNT_W(CNT_W)) u_slots (
    .clk         (clk),
    .rst         (rst),
    .adv         (adv),
    .chan_lvl    (chan_lvl),
    .word_lvl    (word_lvl),
    .frame_start (frame_start),
    .slot_nx     (slot_nx),
    .wslot_nx    (wslot_nx),
    .wch_nx      (wch_nx)
  );

  atx_sample_hold #(.DW(DW)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .load_valid (pair_valid),
    .load_l     (left_smp),
    .load_r     (right_smp),
    .load_ready (pair_ready),
    .take       (frame_start),
    .act_l_nx   (act_l),
    .act_r_nx   (act_r),
    .underrun   (underrun)
  );

  // Configuration is taken only in reset or at a frame start.
  assign fmt_nx   = frame_start ? fmt_e'(fmt_sel) : fmt_q;
  assign armed_nx = armed_q | frame_start;

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      fmt_q <= fmt_e'(fmt_sel);
      inv_q <= clk_inv;
    end
  end

  atx_bit_pick #(.DW(DW), .RJ_DELAY(RJ_DELAY), .CNT_W(CNT_W)) u_pick (
    .fmt   (fmt_nx),
    .slot  (slot_nx),
    .wslot (wslot_nx),
    .chan  (chan_lvl),
    .wch   (wch_nx),
    .left  (act_l),
    .right (act_r),
    .bit_o (pick_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      ser_out <= 1'b0;
    end else begin
      armed_q <= armed_nx;
      if (adv) ser_out <= armed_nx & ~mute & pick_bit;
    end
  end

endmodule

// File: rtl/atx_checker.sv
module atx_checker (
  input logic       clk,
  input logic       rst,
  input logic       adv,
  input logic       frame_start,
  input logic       armed,
  input logic [1:0] fmt_act,
  input logic       mute,
  input logic       ser_out,
  input logic       pair_valid,
  input logic       pair_ready,
  input logic       underrun
);

  // R1: the line moves only on a launch edge
  p_only_on_launch_r1: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ser_out));

  // R6: a muted launch puts out zero
  p_mute_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && mute) |=> !ser_out);

  // R7: nothing leaves before the first frame start
  p_unarmed_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (!armed && !frame_start) |=> !ser_out);

  // R9: an accepted pair fills the holding register
  p_ready_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && pair_ready) |=> !pair_ready);

  // R10: underrun is sticky
  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  // R11: format only moves at a frame start
  p_fmt_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(fmt_act));

endmodule

bind serial_audio_tx atx_checker u_atx_checker (
  .clk         (clk),
  .rst         (rst),
  .adv         (adv),
  .frame_start (frame_start),
  .armed       (armed_q),
  .fmt_act     (fmt_q),
  .mute        (mute),
  .ser_out     (ser_out),
  .pair_valid  (pair_valid),
  .pair_ready  (pair_ready),
  .underrun    (underrun)
);

// File: tb/test_serial_audio_tx.sv
`timescale 1ns/1ps
module test_serial_audio_tx;

  localparam int HB   = 5;   // system clocks per bit-clock phase
  localparam int NBIT = 32;  // bit periods per channel half

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_clk = 1'b1, chan_clk = 1'b0, word_clk = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        clk_inv = 1'b0, mute = 1'b0, pair_valid = 1'b0;
  logic [15:0] left_smp = '0, right_smp = '0;
  logic        pair_ready, ser_out, underrun;

  always #2.5 clk = ~clk;

  serial_audio_tx #(.DW(16), .RJ_DELAY(16), .SYNC_STAGES(2), .CNT_W(8)) i_serial_audio_tx (
    .clk(clk), .rst(rst), .bit_clk(bit_clk), .chan_clk(chan_clk), .word_clk(word_clk),
    .fmt_sel(fmt_sel), .clk_inv(clk_inv), .mute(mute), .pair_valid(pair_valid),
    .pair_ready(pair_ready), .left_smp(left_smp), .right_smp(right_smp),
    .ser_out(ser_out), .underrun(underrun)
  );

  int n_vec = 0, n_bad = 0;
  string extra = "";

  // behavioural reference state
  bit          pol_m, armed_m, prev_lr_m, prev_wc_m, wch_m, urun_m;
  int          mode_m, wk;
  logic [15:0] al, ar;
  logic [31:0] q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit ref_bit(input int md, input int s, input int k, input bit ch,
                                 input bit wc, input logic [15:0] l, input logic [15:0] r);
    logic [15:0] w;
    w = ch ? l : r;
    case (md)
      0: return (s < 16) ? w[15 - s] : 1'b0;
      1: return (s >= 1 && s <= 16) ? w[16 - s] : 1'b0;
      2: return (s >= 16 && s < 32) ? w[31 - s] : 1'b0;
      default: begin
        w = wc ? l : r;
        return (k < 16) ? w[15 - k] : 1'b0;
      end
    endcase
  endfunction

  function automatic logic [31:0] mkpair(input int k);
    if (k == 0) return {16'h8000, 16'h7FFF};
    if (k == 1) return {16'hFFFF, 16'h0001};
    return (32'(k) * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  task automatic do_reset(input int m, input bit p);
    @(negedge clk);
    rst = 1'b1; fmt_sel = 2'(m); clk_inv = p; bit_clk = ~p;
    chan_clk = 1'b0; word_clk = 1'b0; pair_valid = 1'b0; mute = 1'b0;
    repeat (6) @(negedge clk);
    check(ser_out === 1'b0 && pair_ready === 1'b1 && underrun === 1'b0,
          "R7 reset state", {ser_out, pair_ready, underrun}, 3'b010);
    pol_m = p; mode_m = m; armed_m = 0; prev_lr_m = 1; prev_wc_m = 0;
    wk = 1000; wch_m = 0; urun_m = 0; al = '0; ar = '0; q.delete();
    rst = 1'b0;
  endtask

  task automatic bit_period(input bit lrv, input bit wcv, input int s,
                            input bit ld, input logic [31:0] pr);
    bit    exp;
    string tag;
    @(negedge clk);
    bit_clk = pol_m;                  // launch edge
    chan_clk = lrv; word_clk = wcv;
    if (lrv && !prev_lr_m) begin      // frame start (R8)
      armed_m = 1; mode_m = int'(fmt_sel);
      if (q.size() > 0) {al, ar} = q.pop_front();
      else urun_m = 1;
    end
    if (prev_wc_m) begin wk = 0; wch_m = lrv; end
    else wk++;
    prev_wc_m = wcv; prev_lr_m = lrv;
    exp = armed_m && !mute && ref_bit(mode_m, s, wk, lrv, wch_m, al, ar);
    if (!armed_m) tag = "R7";
    else if (mute) tag = "R6";
    else tag = (mode_m == 0) ? "R2" : (mode_m == 1) ? "R3" : (mode_m == 2) ? "R4" : "R5";
    tag = $sformatf("%s%s R8 R10 %s slot %0d", pol_m ? "R1 " : "", tag, extra, s);
    repeat (HB) @(negedge clk);
    bit_clk = ~pol_m;                 // valid edge
    repeat (2) @(negedge clk);
    check(ser_out === exp && underrun === urun_m, tag,
          {ser_out, underrun}, {exp, urun_m});
    @(negedge clk);
    if (ld) begin
      check(pair_ready === 1'b1, "R9 ready before load", pair_ready, 1);
      pair_valid = 1'b1; {left_smp, right_smp} = pr;
      @(negedge clk);
      pair_valid = 1'b0;
      q.push_back(pr);
      check(pair_ready === 1'b0, "R9 ready after load", pair_ready, 0);
    end else begin
      @(negedge clk);
    end
  endtask

  task automatic half(input bit lrv, input int wpos, input bit ld,
                      input logic [31:0] pr, input int chg_slot, input int chg_val);
    for (int s = 0; s < NBIT; s++) begin
      if (s == chg_slot) fmt_sel = 2'(chg_val);
      bit_period(lrv, s == wpos, s, ld && s == 8, pr);
    end
  endtask

  task automatic frame(input int wpos, input bit ld, input logic [31:0] pr,
                       input int chg_slot, input int chg_val);
    half(1'b1, wpos, 1'b0, '0, chg_slot, chg_val);
    half(1'b0, wpos, ld, pr, -1, 0);
  endtask

  bit done = 0;

  initial begin
    int k = 0;
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 4; m++) begin
        int wpos;
        wpos = (m == 3) ? (p == 1 ? 31 : 5) : -1;
        do_reset(m, p[0]);
        half(1'b0, wpos, 1'b1, mkpair(k), -1, 0);
        k++;
        for (int f = 0; f < 3; f++) begin
          frame(wpos, 1'b1, mkpair(k), -1, 0);
          k++;
        end
      end
    end
    // R11: format change in mid-frame applies from the next frame start
    do_reset(0, 1'b0);
    half(1'b0, -1, 1'b1, mkpair(k), -1, 0); k++;
    extra = "R11";
    frame(-1, 1'b1, mkpair(k), 10, 1); k++;
    frame(-1, 1'b1, mkpair(k), -1, 0); k++;
    extra = "";
    // R6: muted frame
    mute = 1'b1;
    frame(-1, 1'b1, mkpair(k), -1, 0); k++;
    mute = 1'b0;
    // R10: skipped load, repeated pair, sticky flag
    frame(-1, 1'b0, '0, -1, 0);
    frame(-1, 1'b1, mkpair(k), -1, 0); k++;
    frame(-1, 1'b1, mkpair(k), -1, 0); k++;
    check(underrun === 1'b1, "R10 sticky underrun", underrun, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired (R1..): got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule